// File: doc/BRIEF.md
# Register-Commanded Bus Bridge Master

This block lets software drive a simple 32-bit peripheral bus through a small 64-bit register port. One write of a 64-bit command word gives the direction, the transfer size, a 24-bit bus address and, for a write, the data. That single write launches one bus transaction. The bridge holds its request on the bus until the target answers with an acknowledge or an error-acknowledge. If neither answer arrives within a parameterised number of cycles, the bridge ends the transaction as a timeout.

Software polls one status word. It shows a busy flag, a read-valid flag, the read data and the classified error flags, including two 6-bit error fields that two downstream masters supply. Error flags build up across transactions until software clears them with a write-to-clear. A second, latched-status register keeps the same build-up and also records commands that arrived while the bridge was busy. A reset register aborts any transaction in flight and returns every register to its reset state.

Top module: `cmd_bus_bridge`

## Requirements
- R1: After reset, the status word (offset 1) and the latched-status word (offset 2) both read zero, and the bus request is low.
- R2: A write to offset 0 while the bridge is idle is accepted. In the next cycle busy (status bit 48, which is bit 16 of the upper half) is 1 and the bus request is high. The request carries these command fields: write enable from bit 63, size from bits 62:61 (00 for 8-bit, 01 for 16-bit, 11 for 32-bit), address from bits 55:32 and write data from bits 31:0. The request and its fields hold steady until a response arrives.
- R3: The status word updates at the clock edge where the bus returns an acknowledge to a read. At that edge busy clears, read-valid (upper bit 17) is set and the low 32 bits hold the read data. A completed write leaves read-valid at 0.
- R4: A read of 8 bits returns only bus data bits 7:0, and a read of 16 bits returns only bits 15:0. In both cases the value is right-aligned and all higher bits are zero.
- R5: When the target returns an error-acknowledge, the bridge sets upper bit 20 and the any-error bit (upper bit 31). Read-valid stays 0 and the read data stays 0.
- R6: If no response arrives, busy stays set for exactly TMO_CYCLES cycles and then clears. The bridge then sets the timeout flag (upper bit 21) and the any-error bit.
- R7: At completion, the two downstream error inputs are captured into upper bits 15:10 and 7:2. A non-zero value in either field sets the any-error bit.
- R8: A write to offset 0 while busy is ignored. The bus request fields do not change, and the write sets the busy-collision flag (upper bit 23) and the any-error bit in the latched-status word only.
- R9: Error flags build up across transactions in both status words. Writing a 1 in bit 63 at offset 1 clears the error flags in both words. This write leaves read-valid and the read data unchanged.
- R10: If a clear and a completion fall in the same cycle, the clear removes only the flags that were already set. The flags from the completing transaction remain set.
- R11: Writing a 1 in bit 63 at offset 4 aborts any transaction in flight. The bus request drops, and both status words and the command readback return to zero.
- R12: A read of offset 0 returns the last accepted command word, all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both reads and writes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |
| bus_req | output | 1 | Bus request, high while a transaction is in flight |
| bus_we | output | 1 | Bus direction, 1 = write |
| bus_size | output | 2 | Bus transfer size code |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Target acknowledge |
| bus_errack | input | 1 | Target error-acknowledge |
| bus_rdata | input | 32 | Target read data |
| dn_err_a | input | 6 | Error field from the first downstream master |
| dn_err_b | input | 6 | Error field from the second downstream master |

## Verification
The contest that matters is between the status write-to-clear and a transaction completing: both change the error flags at the same edge. The bench first leaves a timeout flag standing from an earlier transaction. In the exact cycle the target raises its error-acknowledge, the bench also writes the clear bit. It then requires that the old timeout flag is gone from both status words while the new error-acknowledge flag and the any-error bit remain. A second collision is a command written while busy, which is judged by an unchanged bus address and by the flag in the latched-status word.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  localparam logic [2:0] OFF_CMD   = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_LSTAT = 3'd2;
  localparam logic [2:0] OFF_RST   = 3'd4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_RSVD = 2'b10,
    SZ_WORD = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic        wr;
    xfer_size_e  size;
    logic [23:0] addr;
    logic [31:0] data;
  } bus_cmd_t;

  typedef struct packed {
    logic       proto;
    logic       tmo;
    logic       errack;
    logic [5:0] dn_b;
    logic [5:0] dn_a;
  } err_t;

  function automatic bus_cmd_t parse_cmd(input logic [63:0] w);
    bus_cmd_t r;
    r.wr   = w[63];
    r.size = xfer_size_e'(w[62:61]);
    r.addr = w[55:32];
    r.data = w[31:0];
    return r;
  endfunction

  function automatic logic [31:0] align_rd(input logic [31:0] d, input xfer_size_e s);
    case (s)
      SZ_BYTE: align_rd = {24'd0, d[7:0]};
      SZ_HALF: align_rd = {16'd0, d[15:0]};
      default: align_rd = d;
    endcase
  endfunction

  function automatic err_t merge_err(input err_t old, input err_t fresh, input logic clr);
    logic [14:0] base;
    base = clr ? 15'd0 : old;
    return err_t'(base | fresh);
  endfunction

  function automatic logic [63:0] pack_word(input err_t e, input logic busy,
                                            input logic rv, input logic [31:0] d);
    logic [31:0] hi;
    hi        = '0;
    hi[31]    = e.proto | e.tmo | e.errack | (|e.dn_a) | (|e.dn_b);
    hi[23]    = e.proto;
    hi[21]    = e.tmo;
    hi[20]    = e.errack;
    hi[17]    = rv;
    hi[16]    = busy;
    hi[15:10] = e.dn_b;
    hi[7:2]   = e.dn_a;
    return {hi, d};
  endfunction

endpackage

// File: rtl/bbr_regdec.sv
module bbr_regdec
  import bbr_pkg::*;
(
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic       wbit63,
  input  logic       busy,
  output logic       start,
  output logic       collide,
  output logic       stat_clr,
  output logic       soft_rst
);
  logic cmd_wr;
  assign cmd_wr   = reg_we && (reg_addr == OFF_CMD);
  assign start    = cmd_wr && !busy;
  assign collide  = cmd_wr && busy;
  assign stat_clr = reg_we && (reg_addr == OFF_STAT) && wbit63;
  assign soft_rst = reg_we && (reg_addr == OFF_RST) && wbit63;
endmodule

// File: rtl/bbr_engine.sv
module bbr_engine
  import bbr_pkg::*;
#(
  parameter int TMO_CYCLES = 1024
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        start,
  input  logic [63:0] cmd_word,
  input  logic        bus_ack,
  input  logic        bus_errack,
  output logic        busy,
  output logic [63:0] cmd_q,
  output bus_cmd_t    cur,
  output logic        done,
  output logic        done_ok,
  output logic        done_errack,
  output logic        done_tmo
);
  localparam int CW = (TMO_CYCLES < 2) ? 1 : $clog2(TMO_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign cur         = parse_cmd(cmd_q);
  assign done_errack = busy && bus_errack;
  assign done_ok     = busy && bus_ack && !bus_errack;
  assign done_tmo    = busy && !bus_ack && !bus_errack && (cnt == CNT_LAST);
  assign done        = done_errack || done_ok || done_tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cmd_q <= '0;
      cnt   <= '0;
    end else if (soft_rst) begin
      busy  <= 1'b0;
      cmd_q <= '0;
      cnt   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cmd_q <= cmd_word;
      cnt   <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !soft_rst |=> busy);
  p_hold_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !soft_rst |=> busy && $stable(cmd_q));
  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy && (cmd_q == 64'd0));
endmodule

// File: rtl/bbr_status.sv
module bbr_status
  import bbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        start,
  input  logic        done_ok,
  input  logic        done_errack,
  input  logic        done_tmo,
  input  logic        is_wr,
  input  xfer_size_e  size,
  input  logic [31:0] bus_rdata,
  input  logic [5:0]  dn_err_a,
  input  logic [5:0]  dn_err_b,
  input  logic        collide,
  input  logic        clr,
  output err_t        stat_err,
  output err_t        lat_err,
  output logic        rv,
  output logic [31:0] rdata
);
  err_t fresh, fresh_lat;
  logic fin, rd_ok;

  assign fin   = done_ok || done_errack || done_tmo;
  assign rd_ok = done_ok && !is_wr;

  always_comb begin
    fresh        = '0;
    fresh.errack = done_errack;
    fresh.tmo    = done_tmo;
    fresh.dn_a   = fin ? dn_err_a : 6'd0;
    fresh.dn_b   = fin ? dn_err_b : 6'd0;
    fresh_lat       = fresh;
    fresh_lat.proto = collide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_err <= '0;
      lat_err  <= '0;
      rv       <= 1'b0;
      rdata    <= '0;
    end else if (soft_rst) begin
      stat_err <= '0;
      lat_err  <= '0;
      rv       <= 1'b0;
      rdata    <= '0;
    end else begin
      stat_err <= merge_err(stat_err, fresh, clr);
      lat_err  <= merge_err(lat_err, fresh_lat, clr);
      if (start) begin
        rv    <= 1'b0;
        rdata <= '0;
      end else if (fin) begin
        rv    <= rd_ok;
        rdata <= rd_ok ? align_rd(bus_rdata, size) : 32'd0;
      end
    end
  end

  p_rv_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && !soft_rst |=> rv);
  p_errack_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_errack && !soft_rst |=> stat_err.errack && lat_err.errack);
  p_no_data_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_errack |=> !rv && (rdata == 32'd0));
endmodule

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge
  import bbr_pkg::*;
#(
  parameter int TMO_CYCLES = 1024
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [1:0]  bus_size,
  output logic [23:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic        bus_errack,
  input  logic [31:0] bus_rdata,
  input  logic [5:0]  dn_err_a,
  input  logic [5:0]  dn_err_b
);
  logic        start, collide, stat_clr, soft_rst;
  logic        busy, done, done_ok, done_errack, done_tmo;
  logic [63:0] cmd_q;
  bus_cmd_t    cur;
  err_t        stat_err, lat_err;
  logic        rv;
  logic [31:0] rdata;

  bbr_regdec u_dec (
    .reg_we(reg_we), .reg_addr(reg_addr), .wbit63(reg_wdata[63]), .busy(busy),
    .start(start), .collide(collide), .stat_clr(stat_clr), .soft_rst(soft_rst)
  );

  bbr_engine #(.TMO_CYCLES(TMO_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start), .cmd_word(reg_wdata),
    .bus_ack(bus_ack), .bus_errack(bus_errack), .busy(busy), .cmd_q(cmd_q), .cur(cur),
    .done(done), .done_ok(done_ok), .done_errack(done_errack), .done_tmo(done_tmo)
  );

  bbr_status u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
    .done_ok(done_ok), .done_errack(done_errack), .done_tmo(done_tmo),
    .is_wr(cur.wr), .size(cur.size), .bus_rdata(bus_rdata),
    .dn_err_a(dn_err_a), .dn_err_b(dn_err_b), .collide(collide), .clr(stat_clr),
    .stat_err(stat_err), .lat_err(lat_err), .rv(rv), .rdata(rdata)
  );

  assign bus_req   = busy;
  assign bus_we    = cur.wr;
  assign bus_size  = cur.size;
  assign bus_addr  = cur.addr;
  assign bus_wdata = cur.data;

  always_comb begin
    case (reg_addr)
      OFF_CMD:   reg_rdata = cmd_q;
      OFF_STAT:  reg_rdata = pack_word(stat_err, busy, rv, rdata);
      OFF_LSTAT: reg_rdata = pack_word(lat_err, 1'b0, 1'b0, 32'd0);
      default:   reg_rdata = 64'd0;
    endcase
  end

  p_collide_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> $stable(bus_addr) && $stable(bus_wdata) && lat_err.proto);
  p_done_drops_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bus_req);
  p_tmo_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_tmo && !soft_rst |=> stat_err.tmo);
  p_sizes_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !$isunknown(bus_size));
endmodule

// File: tb/sim_cmd_bus_bridge.sv
module sim_cmd_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0, bus_errack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [5:0]  dn_err_a = '0, dn_err_b = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_bus_bridge #(.TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_errack(bus_errack), .bus_rdata(bus_rdata), .dn_err_a(dn_err_a), .dn_err_b(dn_err_b)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic respond(input int dly, input bit ok, input bit err, input logic [31:0] d);
    repeat (dly) @(negedge clk);
    bus_ack = ok; bus_errack = err; bus_rdata = d;
    @(negedge clk);
    bus_ack = 1'b0; bus_errack = 1'b0; bus_rdata = '0;
  endtask

  function automatic logic [63:0] mk_cmd(input bit wr, input logic [1:0] sz,
                                         input logic [23:0] a, input logic [31:0] d);
    return {wr, sz, 5'd0, a, d};
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    rd_reg(3'd1, v); chk("R1 status", v, 64'd0);
    rd_reg(3'd2, v); chk("R1 latched", v, 64'd0);
    chk("R1 req", {63'd0, bus_req}, 64'd0);
  endtask

  task automatic t_write32();
    logic [63:0] v, c;
    c = mk_cmd(1'b1, 2'b11, 24'h123456, 32'hDEADBEEF);
    wr_reg(3'd0, c);
    rd_reg(3'd1, v); chk("R2 busy", v, 64'h00010000_00000000);
    chk("R2 fields", {bus_req, bus_we, bus_size, bus_addr, bus_wdata},
        {1'b1, 1'b1, 2'b11, 24'h123456, 32'hDEADBEEF});
    rd_reg(3'd0, v); chk("R12 readback", v, c);
    respond(3, 1'b1, 1'b0, 32'hFFFFFFFF);
    rd_reg(3'd1, v); chk("R3 write done", v, 64'd0);
    chk("R3 req low", {63'd0, bus_req}, 64'd0);
  endtask

  task automatic t_read32();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b0, 2'b11, 24'h0ABCDE, 32'h0));
    chk("R2 read dir", {bus_req, bus_we, bus_addr}, {1'b1, 1'b0, 24'h0ABCDE});
    respond(0, 1'b1, 1'b0, 32'h11223344);
    rd_reg(3'd1, v); chk("R3 read data", v, 64'h00020000_11223344);
  endtask

  task automatic t_subword();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b0, 2'b00, 24'h000010, 32'h0));
    respond(1, 1'b1, 1'b0, 32'hAABBCCDD);
    rd_reg(3'd1, v); chk("R4 byte", v, 64'h00020000_000000DD);
    wr_reg(3'd0, mk_cmd(1'b0, 2'b01, 24'h000012, 32'h0));
    respond(2, 1'b1, 1'b0, 32'hAABBCCDD);
    rd_reg(3'd1, v); chk("R4 half", v, 64'h00020000_0000CCDD);
  endtask

  task automatic t_errack_accum();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b0, 2'b11, 24'h000100, 32'h0));
    respond(1, 1'b0, 1'b1, 32'h55555555);
    rd_reg(3'd1, v); chk("R5 errack", v, 64'h80100000_00000000);
    rd_reg(3'd2, v); chk("R5 latched", v, 64'h80100000_00000000);
    wr_reg(3'd0, mk_cmd(1'b0, 2'b11, 24'h000104, 32'h0));
    respond(0, 1'b1, 1'b0, 32'h00000005);
    rd_reg(3'd1, v); chk("R9 accumulate", v, 64'h80120000_00000005);
    wr_reg(3'd1, 64'h80000000_00000000);
    rd_reg(3'd1, v); chk("R9 clear status", v, 64'h00020000_00000005);
    rd_reg(3'd2, v); chk("R9 clear latched", v, 64'd0);
  endtask

  task automatic t_downstream();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b1, 2'b11, 24'h000200, 32'h1));
    dn_err_a = 6'h15; dn_err_b = 6'h2A;
    respond(1, 1'b1, 1'b0, 32'h0);
    dn_err_a = 6'h00; dn_err_b = 6'h00;
    rd_reg(3'd1, v); chk("R7 fields", v, 64'h8000A854_00000000);
    wr_reg(3'd1, 64'h80000000_00000000);
  endtask

  task automatic t_collide();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b1, 2'b11, 24'h00A000, 32'h0000AAAA));
    wr_reg(3'd0, mk_cmd(1'b0, 2'b00, 24'h00B000, 32'h0000BBBB));
    chk("R8 ignored", {bus_req, bus_addr, bus_wdata}, {1'b1, 24'h00A000, 32'h0000AAAA});
    rd_reg(3'd0, v); chk("R8 readback kept", v, mk_cmd(1'b1, 2'b11, 24'h00A000, 32'h0000AAAA));
    respond(0, 1'b1, 1'b0, 32'h0);
    rd_reg(3'd2, v); chk("R8 latched flag", v, 64'h80800000_00000000);
    rd_reg(3'd1, v); chk("R8 status clean", v, 64'd0);
    wr_reg(3'd1, 64'h80000000_00000000);
  endtask

  task automatic t_timeout();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b0, 2'b11, 24'h000300, 32'h0));
    repeat (TMO - 1) @(negedge clk);
    chk("R6 still busy", {63'd0, bus_req}, 64'd1);
    @(negedge clk);
    chk("R6 ended", {63'd0, bus_req}, 64'd0);
    rd_reg(3'd1, v); chk("R6 tmo flag", v, 64'h80200000_00000000);
  endtask

  task automatic t_same_cycle();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b0, 2'b11, 24'h000400, 32'h0));
    @(negedge clk);
    bus_errack = 1'b1;
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 64'h80000000_00000000;
    @(negedge clk);
    bus_errack = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    rd_reg(3'd1, v); chk("R10 status", v, 64'h80100000_00000000);
    rd_reg(3'd2, v); chk("R10 latched", v, 64'h80100000_00000000);
  endtask

  task automatic t_softrst();
    logic [63:0] v;
    wr_reg(3'd0, mk_cmd(1'b1, 2'b11, 24'h000500, 32'h12345678));
    wr_reg(3'd4, 64'h80000000_00000000);
    chk("R11 req dropped", {63'd0, bus_req}, 64'd0);
    rd_reg(3'd1, v); chk("R11 status", v, 64'd0);
    rd_reg(3'd2, v); chk("R11 latched", v, 64'd0);
    rd_reg(3'd0, v); chk("R11 cmd", v, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write32();
    t_read32();
    t_subword();
    t_errack_accum();
    t_downstream();
    t_collide();
    t_timeout();
    t_same_cycle();
    t_softrst();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule